// File: doc/BRIEF.md
# Tagged memory request issuer

This block sits on the user side of a memory controller. A client hands it jobs: a command code, bank, row and column fields, and an urgency flag. The block gives each job a tag taken from a pool of free tags. It presents the job to the controller, along with the tag, and holds it there until the controller takes it. The tag is an index into a small data buffer that the block owns. The client fills the buffer before it issues a write. It reads the buffer back after a read has completed.

No data travels with the command. Later, the controller echoes the tag on a write-fetch port when it wants the write data, and the block must supply that data and its byte mask in the same cycle. The controller also echoes the tag on a read-return port when it delivers read data, and the block stores that data in the named slot. A slot holds several beats, and the controller selects the beat on every transfer. The fetch and return ports can each name any outstanding tag, so completions may arrive in any order.

A tag stays busy from the cycle it is allocated until the last beat of its transfer. Allocation stalls while every tag is busy.

Top module: `mem_req_issuer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the block presents no request (`ctl_req`=0), every tag is free (`tag_busy`=0), `job_tag`=0 and `job_ready`=1.
- R2: While `ctl_req` is high and `ctl_take` is low, the next cycle keeps `ctl_req` high and keeps every `ctl_*` field and `ctl_tag` unchanged.
- R3: When `ctl_req` is low, a high `ctl_take` has no effect: `ctl_req` stays low and `tag_busy` is unchanged.
- R4: `job_tag` shows the lowest-numbered free tag. A job that is taken (`job_valid` and `job_ready` both high) marks that tag busy, and that tag appears on `ctl_tag` in the next cycle.
- R5: When all 2^TAG_W tags are busy, `job_ready` is 0.
- R6: In any cycle where `fetch_en` is high, `fetch_data` and `fetch_mask` equal the word and mask last loaded into slot (`fetch_tag`, `fetch_beat`). They are valid in that same cycle.
- R7: A cycle with `ret_en` high writes `ret_data` into slot (`ret_tag`, `ret_beat`). From the next cycle, `buf_rd_data` returns it for that tag and beat.
- R8: A return beat with `ret_last` high raises `rd_done`, with `rd_done_tag`=`ret_tag`, in the same cycle. That tag is free from the next cycle.
- R9: A fetch beat with `fetch_last` high raises `wr_done`, with `wr_done_tag`=`fetch_tag`, and frees the tag from the next cycle. A fetch beat with `fetch_last` low leaves the tag busy.
- R10: When `ctl_take` is held high, one job is taken in every cycle, with no idle cycles between jobs, until the tags run out.
- R11: `ctl_cmd`, `ctl_bank`, `ctl_row`, `ctl_col` and `ctl_urgent` carry the fields of the job that was taken, unchanged. The command code is not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| job_valid | input | 1 | Client offers a job |
| job_ready | output | 1 | Job is taken this cycle if valid |
| job_cmd | input | CMD_W | Command code of the job |
| job_bank | input | BANK_W | Bank field |
| job_row | input | ROW_W | Row field |
| job_col | input | COL_W | Column field |
| job_urgent | input | 1 | High-priority flag |
| job_tag | output | TAG_W | Tag the next taken job will use |
| buf_wr_en | input | 1 | Client loads a buffer word |
| buf_wr_tag | input | TAG_W | Slot tag for the load |
| buf_wr_beat | input | BEAT_W | Beat within the slot for the load |
| buf_wr_data | input | DATA_W | Word to load |
| buf_wr_mask | input | DATA_W/8 | Byte mask to load |
| buf_rd_tag | input | TAG_W | Slot tag for readback |
| buf_rd_beat | input | BEAT_W | Beat for readback |
| buf_rd_data | output | DATA_W | Readback word |
| ctl_req | output | 1 | Request presented to the controller |
| ctl_take | input | 1 | Controller takes the request |
| ctl_cmd | output | CMD_W | Presented command code |
| ctl_bank | output | BANK_W | Presented bank |
| ctl_row | output | ROW_W | Presented row |
| ctl_col | output | COL_W | Presented column |
| ctl_urgent | output | 1 | Presented priority flag |
| ctl_tag | output | TAG_W | Presented buffer tag |
| fetch_en | input | 1 | Controller fetches a write beat |
| fetch_tag | input | TAG_W | Echoed tag for the fetch |
| fetch_beat | input | BEAT_W | Beat being fetched |
| fetch_last | input | 1 | Final beat of the write |
| fetch_data | output | DATA_W | Write word, same cycle |
| fetch_mask | output | DATA_W/8 | Write byte mask, same cycle |
| ret_en | input | 1 | Controller returns a read beat |
| ret_tag | input | TAG_W | Echoed tag for the return |
| ret_beat | input | BEAT_W | Beat being returned |
| ret_last | input | 1 | Final beat of the read |
| ret_data | input | DATA_W | Returned word |
| rd_done | output | 1 | A read completed |
| rd_done_tag | output | TAG_W | Tag of the completed read |
| wr_done | output | 1 | A write completed |
| wr_done_tag | output | TAG_W | Tag of the completed write |
| tag_busy | output | 2^TAG_W | Busy flag per tag |

## Verification
The assertions check four behaviours on every cycle: a request that is not taken is held with stable fields, a taken job never receives a tag that is already busy, the block stalls when the pool is full, and a presented tag is always marked busy. They also check the state after reset. The bench scenarios are the only way to show data correctness: a fetched word matches what the client loaded, and a returned word lands in the named slot. The scenarios also show that the lowest free tag is chosen after out-of-order completions, that a non-final beat keeps the tag busy, that a take strobe while idle is ignored, and that issue runs back to back.

// File: rtl/mem_req_issuer.sv
module mem_req_issuer #(
  parameter int TAG_W  = 3,
  parameter int BEATS  = 2,
  parameter int DATA_W = 32,
  parameter int CMD_W  = 3,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  localparam int NTAG   = 1 << TAG_W,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int MASK_W = DATA_W / 8,
  localparam int DEPTH  = NTAG * BEATS,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              job_valid,
  output logic              job_ready,
  input  logic [CMD_W-1:0]  job_cmd,
  input  logic [BANK_W-1:0] job_bank,
  input  logic [ROW_W-1:0]  job_row,
  input  logic [COL_W-1:0]  job_col,
  input  logic              job_urgent,
  output logic [TAG_W-1:0]  job_tag,
  input  logic              buf_wr_en,
  input  logic [TAG_W-1:0]  buf_wr_tag,
  input  logic [BEAT_W-1:0] buf_wr_beat,
  input  logic [DATA_W-1:0] buf_wr_data,
  input  logic [MASK_W-1:0] buf_wr_mask,
  input  logic [TAG_W-1:0]  buf_rd_tag,
  input  logic [BEAT_W-1:0] buf_rd_beat,
  output logic [DATA_W-1:0] buf_rd_data,
  output logic              ctl_req,
  input  logic              ctl_take,
  output logic [CMD_W-1:0]  ctl_cmd,
  output logic [BANK_W-1:0] ctl_bank,
  output logic [ROW_W-1:0]  ctl_row,
  output logic [COL_W-1:0]  ctl_col,
  output logic              ctl_urgent,
  output logic [TAG_W-1:0]  ctl_tag,
  input  logic              fetch_en,
  input  logic [TAG_W-1:0]  fetch_tag,
  input  logic [BEAT_W-1:0] fetch_beat,
  input  logic              fetch_last,
  output logic [DATA_W-1:0] fetch_data,
  output logic [MASK_W-1:0] fetch_mask,
  input  logic              ret_en,
  input  logic [TAG_W-1:0]  ret_tag,
  input  logic [BEAT_W-1:0] ret_beat,
  input  logic              ret_last,
  input  logic [DATA_W-1:0] ret_data,
  output logic              rd_done,
  output logic [TAG_W-1:0]  rd_done_tag,
  output logic              wr_done,
  output logic [TAG_W-1:0]  wr_done_tag,
  output logic [NTAG-1:0]   tag_busy
);

  function automatic logic [IDX_W-1:0] slot(input logic [TAG_W-1:0] t, input logic [BEAT_W-1:0] b);
    return IDX_W'(t) * IDX_W'(BEATS) + IDX_W'(b);
  endfunction

  logic [DATA_W-1:0] dmem [DEPTH];
  logic [MASK_W-1:0] mmem [DEPTH];
  logic              free_any;
  logic [TAG_W-1:0]  free_tag;
  logic [NTAG-1:0]   busy_nxt;
  logic              job_fire;

  always_comb begin
    free_any = 1'b0;
    free_tag = '0;
    for (int i = NTAG - 1; i >= 0; i--)
      if (!tag_busy[i]) begin
        free_any = 1'b1;
        free_tag = i[TAG_W-1:0];
      end
  end

  assign job_tag   = free_tag;
  assign job_ready = free_any && (!ctl_req || ctl_take);
  assign job_fire  = job_valid && job_ready;

  assign wr_done     = fetch_en && fetch_last;
  assign wr_done_tag = fetch_tag;
  assign rd_done     = ret_en && ret_last;
  assign rd_done_tag = ret_tag;

  always_comb begin
    busy_nxt = tag_busy;
    if (wr_done) busy_nxt[fetch_tag] = 1'b0;
    if (rd_done) busy_nxt[ret_tag] = 1'b0;
    if (job_fire) busy_nxt[free_tag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_busy   <= '0;
      ctl_req    <= 1'b0;
      ctl_cmd    <= '0;
      ctl_bank   <= '0;
      ctl_row    <= '0;
      ctl_col    <= '0;
      ctl_urgent <= 1'b0;
      ctl_tag    <= '0;
    end else begin
      tag_busy <= busy_nxt;
      if (job_fire) begin
        ctl_req    <= 1'b1;
        ctl_cmd    <= job_cmd;
        ctl_bank   <= job_bank;
        ctl_row    <= job_row;
        ctl_col    <= job_col;
        ctl_urgent <= job_urgent;
        ctl_tag    <= free_tag;
      end else if (ctl_take) begin
        ctl_req <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (buf_wr_en) begin
      dmem[slot(buf_wr_tag, buf_wr_beat)] <= buf_wr_data;
      mmem[slot(buf_wr_tag, buf_wr_beat)] <= buf_wr_mask;
    end
    if (ret_en)
      dmem[slot(ret_tag, ret_beat)] <= ret_data;
  end

  assign fetch_data  = dmem[slot(fetch_tag, fetch_beat)];
  assign fetch_mask  = mmem[slot(fetch_tag, fetch_beat)];
  assign buf_rd_data = dmem[slot(buf_rd_tag, buf_rd_beat)];

endmodule

// File: rtl/mem_req_issuer_chk.sv
module mem_req_issuer_chk #(
  parameter int TAG_W  = 3,
  parameter int CMD_W  = 3,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  localparam int NTAG  = 1 << TAG_W
) (
  input logic              clk,
  input logic              rst,
  input logic              job_valid,
  input logic              job_ready,
  input logic [TAG_W-1:0]  job_tag,
  input logic [NTAG-1:0]   tag_busy,
  input logic              ctl_req,
  input logic              ctl_take,
  input logic [CMD_W-1:0]  ctl_cmd,
  input logic [BANK_W-1:0] ctl_bank,
  input logic [ROW_W-1:0]  ctl_row,
  input logic [COL_W-1:0]  ctl_col,
  input logic              ctl_urgent,
  input logic [TAG_W-1:0]  ctl_tag
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!ctl_req && tag_busy == '0));

  assert_hold_until_take_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_req && !ctl_take) |=> (ctl_req &&
      $stable({ctl_cmd, ctl_bank, ctl_row, ctl_col, ctl_urgent, ctl_tag})));

  assert_alloc_free_tag_R4: assert property (@(posedge clk) disable iff (rst)
    (job_valid && job_ready) |-> !tag_busy[job_tag]);

  assert_stall_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    (&tag_busy) |-> !job_ready);

  assert_no_tag_reuse_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_req |-> tag_busy[ctl_tag]);

endmodule

bind mem_req_issuer mem_req_issuer_chk #(
  .TAG_W(TAG_W), .CMD_W(CMD_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (.*);

// File: tb/sim_mem_req_issuer.sv
`timescale 1ns/1ps
module sim_mem_req_issuer;
  localparam int TAG_W = 3, BEATS = 2, DATA_W = 32, CMD_W = 3, BANK_W = 3, ROW_W = 14, COL_W = 10;
  localparam int NT = 1 << TAG_W, BEAT_W = $clog2(BEATS), MASK_W = DATA_W / 8;
  localparam int FW = CMD_W + BANK_W + ROW_W + COL_W + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic job_valid = 0, job_ready, job_urgent = 0;
  logic [CMD_W-1:0] job_cmd = 0;
  logic [BANK_W-1:0] job_bank = 0;
  logic [ROW_W-1:0] job_row = 0;
  logic [COL_W-1:0] job_col = 0;
  logic [TAG_W-1:0] job_tag;
  logic buf_wr_en = 0;
  logic [TAG_W-1:0] buf_wr_tag = 0, buf_rd_tag = 0;
  logic [BEAT_W-1:0] buf_wr_beat = 0, buf_rd_beat = 0;
  logic [DATA_W-1:0] buf_wr_data = 0, buf_rd_data;
  logic [MASK_W-1:0] buf_wr_mask = 0;
  logic ctl_req, ctl_take = 0, ctl_urgent;
  logic [CMD_W-1:0] ctl_cmd;
  logic [BANK_W-1:0] ctl_bank;
  logic [ROW_W-1:0] ctl_row;
  logic [COL_W-1:0] ctl_col;
  logic [TAG_W-1:0] ctl_tag;
  logic fetch_en = 0, fetch_last = 0;
  logic [TAG_W-1:0] fetch_tag = 0;
  logic [BEAT_W-1:0] fetch_beat = 0;
  logic [DATA_W-1:0] fetch_data;
  logic [MASK_W-1:0] fetch_mask;
  logic ret_en = 0, ret_last = 0;
  logic [TAG_W-1:0] ret_tag = 0;
  logic [BEAT_W-1:0] ret_beat = 0;
  logic [DATA_W-1:0] ret_data = 0;
  logic rd_done, wr_done;
  logic [TAG_W-1:0] rd_done_tag, wr_done_tag;
  logic [NT-1:0] tag_busy;

  mem_req_issuer #(.TAG_W(TAG_W), .BEATS(BEATS), .DATA_W(DATA_W), .CMD_W(CMD_W),
                   .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u0 (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  logic [DATA_W-1:0] ed [NT][BEATS];
  logic [MASK_W-1:0] em [NT][BEATS];
  logic [FW-1:0] exp_f;
  logic [TAG_W-1:0] exp_t;

  task automatic ceq(input string r, input logic [63:0] a, input logic [63:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, a, e);
    end
  endtask

  function automatic logic [FW-1:0] ctl_fields();
    return {ctl_cmd, ctl_bank, ctl_row, ctl_col, ctl_urgent};
  endfunction

  task automatic load(input logic [TAG_W-1:0] t);
    for (int b = 0; b < BEATS; b++) begin
      buf_wr_en = 1; buf_wr_tag = t; buf_wr_beat = b[BEAT_W-1:0];
      buf_wr_data = $urandom; buf_wr_mask = MASK_W'($urandom);
      ed[t][b] = buf_wr_data; em[t][b] = buf_wr_mask;
      @(negedge clk);
    end
    buf_wr_en = 0;
  endtask

  task automatic submit(input logic is_wr, output logic [TAG_W-1:0] t);
    job_valid = 1; job_cmd = is_wr ? 3'd0 : 3'd1;
    job_bank = BANK_W'($urandom); job_row = ROW_W'($urandom);
    job_col = COL_W'($urandom); job_urgent = 1'($urandom);
    #1;
    while (!job_ready) begin @(negedge clk); #1; end
    t = job_tag;
    exp_f = {job_cmd, job_bank, job_row, job_col, job_urgent};
    exp_t = t;
    @(negedge clk);
    job_valid = 0;
  endtask

  task automatic present(input int stalls);
    ctl_take = 0;
    for (int s = 0; s < stalls; s++) begin
      #1;
      ceq("R2 held req", ctl_req, 1);
      ceq("R2 held fields", ctl_fields(), exp_f);
      ceq("R2 held tag", ctl_tag, exp_t);
      @(negedge clk);
    end
    ctl_take = 1;
    #1;
    ceq("R11 fields", ctl_fields(), exp_f);
    ceq("R4 ctl_tag", ctl_tag, exp_t);
    @(negedge clk);
    ctl_take = 0;
    #1;
    ceq("R2 req dropped after take", ctl_req, 0);
  endtask

  task automatic wbeats(input logic [TAG_W-1:0] t);
    for (int b = 0; b < BEATS; b++) begin
      fetch_en = 1; fetch_tag = t; fetch_beat = b[BEAT_W-1:0]; fetch_last = (b == BEATS - 1);
      #1;
      ceq("R6 fetch data", fetch_data, ed[t][b]);
      ceq("R6 fetch mask", fetch_mask, em[t][b]);
      if (fetch_last) ceq("R9 wr_done", {wr_done, wr_done_tag}, {1'b1, t});
      else ceq("R9 busy on mid beat", tag_busy[t], 1);
      @(negedge clk);
    end
    fetch_en = 0; fetch_last = 0;
    #1;
    ceq("R9 freed after last beat", tag_busy[t], 0);
  endtask

  task automatic rbeats(input logic [TAG_W-1:0] t);
    for (int b = 0; b < BEATS; b++) begin
      ret_en = 1; ret_tag = t; ret_beat = b[BEAT_W-1:0]; ret_last = (b == BEATS - 1);
      ret_data = $urandom; ed[t][b] = ret_data;
      #1;
      if (ret_last) ceq("R8 rd_done", {rd_done, rd_done_tag}, {1'b1, t});
      else ceq("R8 no done mid beat", rd_done, 0);
      @(negedge clk);
    end
    ret_en = 0; ret_last = 0;
    #1;
    ceq("R8 freed after last beat", tag_busy[t], 0);
    for (int b = 0; b < BEATS; b++) begin
      buf_rd_tag = t; buf_rd_beat = b[BEAT_W-1:0];
      #1;
      ceq("R7 stored read data", buf_rd_data, ed[t][b]);
    end
  endtask

  initial begin : main
    logic [TAG_W-1:0] t;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    ceq("R1 req in reset", ctl_req, 0);
    ceq("R1 busy in reset", tag_busy, 0);
    rst = 0;
    @(negedge clk); #1;
    ceq("R1 req", ctl_req, 0);
    ceq("R1 busy", tag_busy, 0);
    ceq("R1 job_tag", job_tag, 0);
    ceq("R1 job_ready", job_ready, 1);

    ctl_take = 1;
    repeat (3) @(negedge clk);
    #1;
    ceq("R3 idle take req", ctl_req, 0);
    ceq("R3 idle take busy", tag_busy, 0);
    ctl_take = 0;
    @(negedge clk);

    for (int it = 0; it < 30; it++) begin
      logic is_wr;
      is_wr = 1'($urandom);
      #1;
      ceq("R4 lowest free when idle", job_tag, 0);
      @(negedge clk);
      if (is_wr) load(job_tag);
      submit(is_wr, t);
      present($urandom % 4);
      if (is_wr) wbeats(t); else rbeats(t);
      repeat ($urandom % 3) @(negedge clk);
    end

    ctl_take = 1;
    for (int i = 0; i < NT; i++) begin
      job_valid = 1; job_cmd = 3'd1;
      job_bank = BANK_W'($urandom); job_row = ROW_W'($urandom);
      job_col = COL_W'($urandom); job_urgent = 1'($urandom);
      #1;
      ceq("R10 back-to-back ready", job_ready, 1);
      ceq("R4 sequential tag", job_tag, i);
      if (i > 0) ceq("R10 presented prev tag", {ctl_req, ctl_tag}, {1'b1, TAG_W'(i - 1)});
      @(negedge clk);
    end
    #1;
    ceq("R5 stall when full", job_ready, 0);
    job_valid = 0;
    @(negedge clk);
    ctl_take = 0;
    #1;
    ceq("R10 last taken", ctl_req, 0);
    ceq("R5 all busy", tag_busy, {NT{1'b1}});
    for (int k = NT - 1; k >= 0; k--) begin
      @(negedge clk);
      rbeats(TAG_W'(k));
      ceq("R4 lowest free after out-of-order", job_tag, k);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule